// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a byte-level I2C bus master that software steers through four byte-wide registers: control, status, own address and data. Software places a byte in the data register, then writes the status register to select master transmit or master receive and to request a START. The controller puts out the START, shifts the byte onto SDA most significant bit first, and samples the ninth (acknowledge) bit. It then raises a pending flag, drives its interrupt if enabled, and holds SCL low until software clears the flag.

Each later byte is sent or received according to the selected mode. A STOP or a repeated START is requested by writing the busy bit of the status register. The request takes effect only once the pending flag has been cleared. The SCL rate comes from a prescaler and a 4-bit divider in the control register. SCL and SDA are open-drain style outputs, where 1 means released. SDA is read back on its own input, both to receive data and to detect a lost arbitration.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control, status, own-address and data registers read 0x00, irq is low, and scl_o and sda_o are both 1 (released).
- R2: reg_sel selects the register: 0 control, 1 status, 2 own address, 3 data. The control fields are bit 7 ACK enable, bit 6 slow prescaler, bit 5 interrupt enable, bit 4 pending and bits 3:0 divider n. The status fields are bits 7:6 mode (11 master transmit, 10 master receive), bit 5 busy, bit 4 output enable, bit 3 arbitration lost and bit 0 last ACK bit; bits 2:1 read 0. The written control fields and the own address read back unchanged.
- R3: Writing status with bit 5 = 1 and bit 7 = 1 while idle first produces a START, in which SDA falls while SCL is high. The controller then transmits the data register contents MSB first. Software forms the address byte as (7-bit address << 1) | read.
- R4: At the end of every byte the pending bit (control bit 4) is set, and irq equals interrupt enable AND pending. While pending is set, SCL stays low. Software can clear pending by writing 0 to it, but writing 1 never sets it.
- R5: Status bit 0 holds the SDA level sampled on the ninth clock of the last byte, where 1 means NACK.
- R6: In master receive mode (status 7:6 = 10), each byte after the address is shifted in MSB first and lands in the data register. On the ninth bit the master drives SDA low when control bit 7 is 1 and leaves it released (NACK) when it is 0.
- R7: Writing status bit 5 = 0 while busy queues a STOP. The STOP is held off while pending is set and, once pending is cleared, SDA rises while SCL is high. After the STOP, busy reads 0.
- R8: Writing status bit 5 = 1 while a byte is held queues a repeated START. Once pending is cleared, the repeated START is issued and the new contents of the data register are sent as the next address byte.
- R9: Each SCL high phase lasts 8*(n+1) clock cycles when control bit 6 is 0, and 256*(n+1) cycles when it is 1.
- R10: SDA changes only while SCL is low, apart from the START and STOP edges. The number of START and STOP conditions on the bus equals the number software requested.
- R11: A data register write is ignored from START until the end of the byte in flight. While the controller holds the bus, a data register write is accepted.
- R12: If SDA reads low while the master releases it during a transmitted bit, status bit 3 and pending are set, both lines are released and busy drops to 0. Any status write clears bit 3.
- R13: When a hardware set of pending and a software clear of pending fall in the same cycle, the set wins and the bus stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register index (byte offset divided by four) |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | SDA line level |

## Verification
Two events can fall in the same clock cycle. In one, the controller sets the pending flag at the end of a byte; in the other, software writes a clear of that same flag. The bench provokes the collision by writing a pending clear on every cycle of a byte transfer and stopping only when the interrupt is first seen high. The outcome is judged correct only if the interrupt then stays high and SCL stays low for many cycles, with no further byte started.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int FAST_HALF = 8,
  parameter int SLOW_HALF = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int CW = $clog2(SLOW_HALF * 16 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_RS1, S_RS2, S_STOP1, S_STOP2} st_t;
  st_t st;

  logic          ack_en, slow, ie, pend;
  logic [3:0]    ndiv;
  logic [1:0]    mode;
  logic          oe, arb, ackb;
  logic [7:0]    own, dreg, shreg;
  logic [3:0]    bitcnt;
  logic          ph, tx, start_req, stop_req;
  logic [CW-1:0] cnt, half;
  logic          sda_nx;

  wire busy     = (st != S_IDLE);
  wire shifting = (st == S_START) || (st == S_BIT) || (st == S_RS1) || (st == S_RS2);
  wire wr_ctl   = wr_en && reg_sel == 2'd0;
  wire wr_sta   = wr_en && reg_sel == 2'd1;
  wire wr_own   = wr_en && reg_sel == 2'd2;
  wire wr_dat   = wr_en && reg_sel == 2'd3;

  assign half  = (slow ? CW'(SLOW_HALF) : CW'(FAST_HALF)) * (CW'(ndiv) + CW'(1));
  wire   tick  = (cnt >= half - CW'(1));
  assign irq   = ie & pend;
  assign scl_o = (st == S_IDLE) || (st == S_START) || (st == S_RS2) ||
                 (st == S_STOP2) || (st == S_BIT && ph);

  always_comb begin
    case (st)
      S_START, S_STOP1, S_STOP2: sda_nx = 1'b0;
      S_BIT: if (bitcnt < 4'd8) sda_nx = tx ? shreg[7] : 1'b1;
             else               sda_nx = tx ? 1'b1 : ~ack_en;
      default: sda_nx = 1'b1;
    endcase
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rdata = {ack_en, slow, ie, pend, ndiv};
      2'd1:    rdata = {mode, busy, oe, arb, 2'b00, ackb};
      2'd2:    rdata = own;
      default: rdata = dreg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (st == S_IDLE || st == S_HOLD || tick) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_o <= 1'b1;
    else        sda_o <= ~oe | sda_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ack_en <= 1'b0; slow <= 1'b0; ie <= 1'b0; pend <= 1'b0; ndiv <= '0;
      mode <= 2'b00; oe <= 1'b0; arb <= 1'b0; ackb <= 1'b0; own <= '0; dreg <= '0;
      shreg <= '0; bitcnt <= '0; ph <= 1'b0; tx <= 1'b0; start_req <= 1'b0; stop_req <= 1'b0;
    end else begin
      if (wr_ctl) begin
        {ack_en, slow, ie} <= wdata[7:5];
        ndiv <= wdata[3:0];
        pend <= pend & wdata[4];
      end
      if (wr_sta) begin
        mode <= wdata[7:6];
        oe   <= wdata[4];
        arb  <= 1'b0;
        if (wdata[5]) begin start_req <= wdata[7]; stop_req <= 1'b0; end
        else begin start_req <= 1'b0; stop_req <= busy; end
      end
      if (wr_own) own <= wdata;
      if (wr_dat && !shifting) dreg <= wdata;

      case (st)
        S_IDLE: if (start_req && !pend) begin
          st <= S_START; start_req <= 1'b0; shreg <= dreg; tx <= 1'b1;
        end
        S_START: if (tick) begin st <= S_BIT; bitcnt <= '0; ph <= 1'b0; end
        S_BIT: if (tick) begin
          ph <= ~ph;
          if (ph) begin
            if (bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
              if (tx && sda_o && !sda_i) begin arb <= 1'b1; pend <= 1'b1; st <= S_IDLE; end
            end else begin
              ackb <= sda_i; pend <= 1'b1; st <= S_HOLD;
              if (!tx) dreg <= shreg;
            end
          end
        end
        S_HOLD: if (!pend) begin
          if (stop_req)       begin st <= S_STOP1; stop_req <= 1'b0; end
          else if (start_req) begin st <= S_RS1; start_req <= 1'b0; end
          else begin st <= S_BIT; bitcnt <= '0; ph <= 1'b0; tx <= mode[0]; shreg <= dreg; end
        end
        S_RS1:   if (tick) st <= S_RS2;
        S_RS2:   if (tick) begin st <= S_START; shreg <= dreg; tx <= 1'b1; end
        S_STOP1: if (tick) st <= S_STOP2;
        S_STOP2: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && pend) |=> (st == S_HOLD && !scl_o));
  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(st) == S_BIT));
  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && sda_o != $past(sda_o)) |-> (st == S_START || st == S_IDLE));
  // R11
  data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START || (st == S_BIT && bitcnt < 4'd8)) |=> $stable(dreg));
  // R12
  arb_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (st == S_IDLE && pend && scl_o));
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0] adr = 2'd0;
  logic [7:0] wd = 8'h00, rdata;
  logic irq, scl_line, sda_o, sl_sda = 1'b1;
  wire sda_line = sda_o & sl_sda;
  int checks = 0, errors = 0, exp_start = 0, exp_stop = 0;
  logic done = 1'b0;

  i2c_byte_master uut (.clk(clk), .rst_n(rst_n), .reg_sel(adr), .wr_en(we), .wdata(wd),
    .rdata(rdata), .irq(irq), .scl_o(scl_line), .sda_o(sda_o), .sda_i(sda_line));

  always #4 clk = ~clk;

  // bus slave model
  int starts = 0, seen = 0, sb = 0, stops = 0, arb_pos = -1;
  logic [7:0] rx_sh = 8'h00, rx_byte = 8'h00, sl_txb = 8'h00;
  logic ack_seen = 1'b1, sl_tx = 1'b0, sl_ack = 1'b1;
  event reeval;

  function automatic int pos_now();
    return (starts != seen) ? 0 : sb % 9;
  endfunction
  function automatic logic slave_bit(int p);
    if (arb_pos == p) return 1'b0;
    if (p == 8) return sl_tx ? 1'b1 : ~sl_ack;
    if (sl_tx) return sl_txb[7-p];
    return 1'b1;
  endfunction

  always @(negedge sda_line) if (rst_n && scl_line) starts++;
  always @(posedge sda_line) if (rst_n && scl_line) stops++;
  always @(posedge scl_line) begin
    int p;
    if (rst_n) begin
      if (starts != seen) begin seen = starts; sb = 0; end
      p = sb % 9;
      if (p < 8) rx_sh = {rx_sh[6:0], sda_line};
      if (p == 7) rx_byte = rx_sh;
      if (p == 8) ack_seen = sda_line;
      sb++;
    end
  end
  always @(negedge scl_line or reeval) sl_sda = slave_bit(pos_now());

  task automatic slave_cfg(input logic tx, input logic [7:0] b, input logic ack);
    sl_tx = tx; sl_txb = b; sl_ack = ack; -> reeval;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); adr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); adr = a; #1; v = rdata;
  endtask

  logic cfg_ack = 1'b1, cfg_slow = 1'b0;
  logic [3:0] cfg_n = 4'd0;
  task automatic set_ctl(); wr(2'd0, {cfg_ack, cfg_slow, 1'b1, 1'b0, cfg_n}); endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    check(req, irq, 1);
  endtask
  task automatic start_tx(input logic [7:0] abyte, input logic [7:0] sv);
    wr(2'd3, abyte); wr(2'd1, sv); exp_start++;
  endtask
  task automatic stop_xfer(input logic [7:0] sv);
    logic [7:0] v;
    int n = 0;
    wr(2'd1, sv);
    repeat (20) @(negedge clk);
    rd(2'd1, v);
    check("R7 stop deferred busy/scl", {v[5], scl_line}, 2'b10);
    set_ctl();
    v = 8'hFF;
    while (v[5] && n < 2000) begin rd(2'd1, v); n++; end
    check("R7 busy after stop", v[5], 0);
    exp_stop++;
  endtask

  // write transfers: {addr7, data, addr_nack, data_nack}
  localparam logic [16:0] XFERS [4] = '{
    {7'h50, 8'hA5, 1'b0, 1'b0},
    {7'h2A, 8'h00, 1'b0, 1'b1},
    {7'h7F, 8'hFF, 1'b1, 1'b0},
    {7'h01, 8'h96, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2'd0, v); check("R1 control", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 own", v, 8'h00);
    rd(2'd3, v); check("R1 data", v, 8'h00);
    check("R1 pins", {irq, scl_line, sda_line}, 3'b011);
    // R2
    wr(2'd2, 8'h10); rd(2'd2, v); check("R2 own readback", v, 8'h10);
    wr(2'd0, 8'hCB); rd(2'd0, v); check("R2 control readback", v, 8'hCB);
    // R4 software cannot set pending
    wr(2'd0, 8'hB0); rd(2'd0, v);
    check("R4 write 1 to pending", {v, irq}, {8'hA0, 1'b0});
    set_ctl();

    foreach (XFERS[i]) begin
      logic [7:0] ab;
      ab = {XFERS[i][16:10], 1'b0};
      slave_cfg(1'b0, 8'h00, ~XFERS[i][1]);
      start_tx(ab, 8'hF0);
      wait_irq("R4 irq after address");
      check("R3 address byte", rx_byte, ab);
      rd(2'd1, v); check("R5 address ack bit", v[0], XFERS[i][1]);
      repeat (40) @(negedge clk);
      check("R4 scl held while pending", {irq, scl_line}, 2'b10);
      wr(2'd3, XFERS[i][9:2]);
      slave_cfg(1'b0, 8'h00, ~XFERS[i][0]);
      set_ctl();
      wait_irq("R4 irq after data");
      check("R3 data byte", rx_byte, XFERS[i][9:2]);
      rd(2'd1, v); check("R5 data ack bit", v[0], XFERS[i][0]);
      slave_cfg(1'b0, 8'h00, 1'b1);
      stop_xfer(8'hD0);
    end

    // R6 master receive
    start_tx(8'h91, 8'hB0);
    wait_irq("R6 irq after address");
    check("R6 read address", rx_byte, 8'h91);
    slave_cfg(1'b1, 8'hC3, 1'b0);
    set_ctl();
    wait_irq("R6 irq after byte 1");
    rd(2'd3, v); check("R6 received byte 1", v, 8'hC3);
    check("R6 master ACK", ack_seen, 0);
    slave_cfg(1'b1, 8'h3E, 1'b0);
    cfg_ack = 1'b0; set_ctl();
    wait_irq("R6 irq after byte 2");
    rd(2'd3, v); check("R6 received byte 2", v, 8'h3E);
    check("R6 master NACK", ack_seen, 1);
    rd(2'd1, v); check("R5 NACK in status", v[0], 1);
    slave_cfg(1'b0, 8'h00, 1'b1);
    stop_xfer(8'h90);
    cfg_ack = 1'b1; set_ctl();

    // R11 data writes during shift
    start_tx(8'hAA, 8'hF0);
    repeat (40) @(negedge clk);
    wr(2'd3, 8'h11);
    wait_irq("R11 irq");
    rd(2'd3, v); check("R11 write during shift ignored", v, 8'hAA);
    check("R11 byte on bus", rx_byte, 8'hAA);
    wr(2'd3, 8'h11); rd(2'd3, v); check("R11 write while held", v, 8'h11);
    stop_xfer(8'hD0);

    // R8 repeated start
    start_tx(8'h40, 8'hF0);
    wait_irq("R8 irq first address");
    wr(2'd3, 8'h43); wr(2'd1, 8'hB0); exp_start++;
    repeat (20) @(negedge clk);
    check("R8 start deferred", {starts, scl_line}, {exp_start - 1, 1'b0});
    set_ctl();
    wait_irq("R8 irq second address");
    check("R8 repeated start seen", starts, exp_start);
    check("R8 second address", rx_byte, 8'h43);
    rd(2'd1, v); check("R8 still busy", v[5], 1);
    stop_xfer(8'h90);

    // R9 SCL timing
    for (int k = 0; k < 3; k++) begin
      int exp_c;
      cfg_slow = (k == 2);
      cfg_n = (k == 1) ? 4'd3 : 4'd0;
      exp_c = (k == 2) ? 256 : 8 * (int'(cfg_n) + 1);
      set_ctl();
      start_tx(8'hA0, 8'hF0);
      c = 0;
      @(posedge scl_line);
      while (1) begin @(negedge clk); if (scl_line) c++; else break; end
      check("R9 SCL high cycles", c, exp_c);
      wait_irq("R9 irq");
      stop_xfer(8'hD0);
    end
    cfg_slow = 1'b0; cfg_n = 4'd0; set_ctl();

    // R12 arbitration lost
    arb_pos = 1; -> reeval;
    start_tx(8'hFE, 8'hF0);
    wait_irq("R12 irq on arbitration");
    rd(2'd1, v); check("R12 arb set busy clear", {v[5], v[3]}, 2'b01);
    check("R12 scl released", scl_line, 1);
    arb_pos = -1; -> reeval; exp_stop++;
    @(negedge clk);
    set_ctl(); wr(2'd1, 8'hD0);
    rd(2'd1, v); check("R12 arb cleared by status write", v[3], 0);

    // R13 set versus clear in the same cycle
    start_tx(8'h5C, 8'hF0);
    @(negedge clk); adr = 2'd0; wd = 8'h20; we = 1'b1;
    c = 0;
    while (!irq && c < 20000) begin @(negedge clk); c++; end
    we = 1'b0;
    check("R13 pending seen", irq, 1);
    repeat (60) @(negedge clk);
    check("R13 pending kept, bus held", {irq, scl_line}, 2'b10);
    check("R13 byte on bus", rx_byte, 8'h5C);
    stop_xfer(8'hD0);

    // R10
    repeat (10) @(negedge clk);
    check("R10 START count", starts, exp_start);
    check("R10 STOP count", stops, exp_stop);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule